// File: doc/BRIEF.md
# Configuration Port Endian Bridge

This block is the CPU-side register window of a host bridge. It holds a control word with an endian bit, a PCI command word, and a configuration address and data port pair. An access to the data port becomes one configuration read or write on a simple downstream request/response interface.

Two byte-reversal controls apply, and they are independent of each other. The first covers every 32-bit word that crosses the register window. The second covers configuration data only, and it is skipped whenever the configuration address selects bus 0, device 0, which is the bridge's own function.

The data port goes quiet when the enable bit of the address word is clear. In that state a write is dropped and a read returns all ones, and neither produces a downstream request. A read that does go downstream holds the CPU side busy until the response arrives.

Top module: `cfgwin_bridge`

## Requirements
- R1: After reset, the control, command and configuration address words read as zero, `cpu_busy`, `cpu_rvalid` and `dn_req` are low, and the window swap is active.
- R2: When bit 12 of the control word (offset 0x000) is 0, every word written or read through the window is byte-reversed (bytes 3,2,1,0 become 0,1,2,3). When that bit is 1, words pass through unchanged. The setting in force before a write applies to that write.
- R3: The word index is `cpu_addr[11:2]`. Index 0 is control, 1 is command, 2 is configuration address and 3 is configuration data. Reads of any other index return zero, and writes to them change no register.
- R4: A write to the configuration address word keeps only the bits under mask 0x80FF_FFFC. Bits [30:24] and [1:0] read back as zero, and `dn_addr` always shows the stored word.
- R5: With address bit 31 clear, a write to the data port produces no downstream request.
- R6: With address bit 31 clear, a read of the data port returns 0xFFFF_FFFF with `cpu_rvalid` one cycle after the request, and raises neither `dn_req` nor `cpu_busy`.
- R7: Configuration data, in both directions, receives an extra byte reversal when command bit 0 is 0 and address bits [23:11] are not all zero. This reversal combines with the window reversal.
- R8: When address bits [23:11] are all zero, configuration data receives no command-controlled reversal, whatever command bit 0 holds.
- R9: An enabled data-port access pulses `dn_req` for one cycle in the cycle after the request. `dn_we` marks a write, `dn_addr` carries the full address word, and `dn_wdata` carries the write data.
- R10: An enabled data-port read holds `cpu_busy` high from the cycle after the request until a `dn_rvalid` strobe arrives. `cpu_rvalid` rises in the cycle after the strobe, carrying the converted response, and `cpu_busy` drops at that point.
- R11: Reads that do not go downstream give `cpu_rvalid` one cycle after the request. Requests made while `cpu_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Word index, byte address bits [11:2] |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data strobe |
| cpu_busy | output | 1 | Configuration read in flight |
| dn_req | output | 1 | Downstream configuration request strobe |
| dn_we | output | 1 | Downstream request is a write |
| dn_addr | output | 32 | Configuration address word |
| dn_wdata | output | 32 | Downstream write data |
| dn_rvalid | input | 1 | Downstream read response strobe |
| dn_rdata | input | 32 | Downstream read response data |

## Verification
A corrupt control or command bit does not stay hidden: it shows as a byte-reversed value on the very next read of any register, or on the `dn_wdata` of the next configuration write. A wrong device-field test shows up as reversed data only for bus 0, device 0, or only for other targets. For that reason every combination of the two swap bits is exercised against both kinds of target. A sequencer stuck in its wait state shows as `cpu_busy` that never drops and as CPU requests that are silently lost. A sequencer that leaves the wait state too early shows as `cpu_rvalid` ahead of the response strobe, one cycle after the request.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int unsigned CW_DW    = 32;
  localparam int unsigned CW_AW    = 12;
  localparam int unsigned CW_IDX_W = CW_AW - 2;

  // word indices inside the window
  localparam logic [CW_IDX_W-1:0] IDX_CTRL  = CW_IDX_W'(0);
  localparam logic [CW_IDX_W-1:0] IDX_CMD   = CW_IDX_W'(1);
  localparam logic [CW_IDX_W-1:0] IDX_CADDR = CW_IDX_W'(2);
  localparam logic [CW_IDX_W-1:0] IDX_CDATA = CW_IDX_W'(3);

  localparam logic [CW_DW-1:0] CADDR_MASK = 32'h80FF_FFFC;

  localparam int unsigned ENDIAN_BIT  = 12;
  localparam int unsigned CMDSWAP_BIT = 0;
  localparam int unsigned CEN_BIT     = 31;
  localparam int unsigned DEV_LO      = 11;
  localparam int unsigned DEV_HI      = 23;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic ctrl;
    logic cmd;
    logic caddr;
    logic cdata;
  } hit_t;
endpackage

// File: rtl/cfgwin_rst_sync.sv
module cfgwin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cfgwin_bswap.sv
module cfgwin_bswap #(
  parameter int unsigned DW = 32
) (
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] rev;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign rev[g*8 +: 8] = din[(NB-1-g)*8 +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int unsigned     DW   = CW_DW,
  parameter logic [DW-1:0]   MASK = CADDR_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hit_t          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] caddr_o
);
  logic [DW-1:0] ctrl_q, ctrl_n;
  logic [DW-1:0] cmd_q, cmd_n;
  logic [DW-1:0] caddr_q, caddr_n;

  always_comb begin
    ctrl_n  = ctrl_q;
    cmd_n   = cmd_q;
    caddr_n = caddr_q;
    if (wr.ctrl)  ctrl_n  = wdata;
    if (wr.cmd)   cmd_n   = wdata;
    if (wr.caddr) caddr_n = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      caddr_q <= '0;
    end else begin
      if (wr.ctrl)  ctrl_q  <= ctrl_n;
      if (wr.cmd)   cmd_q   <= cmd_n;
      if (wr.caddr) caddr_q <= caddr_n;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cmd_o   = cmd_q;
  assign caddr_o = caddr_q;

  // R4: stored address is the written word under the mask
  a_r4_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr.caddr |=> caddr_o == ($past(wdata) & MASK));

  // R3: words change only through their own write strobe
  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.cmd |=> $stable(cmd_o));
endmodule

// File: rtl/cfgwin_cfgseq.sv
module cfgwin_cfgseq
  import cfgwin_pkg::*;
#(
  parameter int unsigned DW = CW_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          we_i,
  input  logic          data_hit_i,
  input  logic          cfg_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rsp_i,
  input  logic          dn_rvalid_i,
  output logic          busy_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          dn_req_o,
  output logic          dn_we_o,
  output logic [DW-1:0] dn_wdata_o
);
  seq_state_e    state_q, state_n;
  logic          rvalid_q, rvalid_n;
  logic          req_q, req_n;
  logic          we_q, we_n;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] wd_q;
  logic          rd_load, wd_load;

  always_comb begin
    state_n  = state_q;
    rvalid_n = 1'b0;
    req_n    = 1'b0;
    we_n     = we_q;
    rd_load  = 1'b0;
    wd_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_i) begin
          if (we_i) begin
            if (data_hit_i && cfg_en_i) begin
              req_n   = 1'b1;
              we_n    = 1'b1;
              wd_load = 1'b1;
            end
          end else if (data_hit_i && cfg_en_i) begin
            req_n   = 1'b1;
            we_n    = 1'b0;
            state_n = ST_WAIT;
          end else begin
            rvalid_n = 1'b1;
            rd_load  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (dn_rvalid_i) begin
          rvalid_n = 1'b1;
          rd_load  = 1'b1;
          state_n  = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rvalid_q <= 1'b0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      rdata_q  <= '0;
      wd_q     <= '0;
    end else begin
      state_q  <= state_n;
      rvalid_q <= rvalid_n;
      req_q    <= req_n;
      we_q     <= we_n;
      if (rd_load) rdata_q <= rsp_i;
      if (wd_load) wd_q    <= wdata_i;
    end
  end

  assign busy_o     = (state_q == ST_WAIT);
  assign rvalid_o   = rvalid_q;
  assign rdata_o    = rdata_q;
  assign dn_req_o   = req_q;
  assign dn_we_o    = we_q;
  assign dn_wdata_o = wd_q;

  // R5: a downstream request only follows an enabled data-port access
  a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o |-> $past(acc_i && data_hit_i && cfg_en_i));

  // R9: a read request is a single pulse and the port goes busy
  a_r9_read_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o && !dn_we_o |=> !dn_req_o && busy_o);

  // R10: busy holds until the response strobe
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !dn_rvalid_i |=> busy_o);

  // R10: no read data while waiting
  a_r10_no_early_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !rvalid_o);

  // R11: read data follows an accepted read or a response
  a_r11_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> ($past(acc_i && !we_i) || $past(busy_o && dn_rvalid_i)));
endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
  import cfgwin_pkg::*;
#(
  parameter int unsigned DW = CW_DW,
  parameter int unsigned AW = CW_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:2] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid,
  output logic          cpu_busy,
  output logic          dn_req,
  output logic          dn_we,
  output logic [DW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_rvalid,
  input  logic [DW-1:0] dn_rdata
);
  localparam int unsigned IW = AW - 2;

  logic          rst_n_s;
  logic          acc;
  hit_t          hit, wr_hit;
  logic [DW-1:0] ctrl, cmd, caddr;
  logic          win_sw, cfg_sw, cfg_en;
  logic [DW-1:0] host_w, cfg_w, cfg_r, local_r, sel_r, rsp;

  cfgwin_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign acc = cpu_req && !cpu_busy;

  always_comb begin
    hit.ctrl  = (cpu_addr == IW'(IDX_CTRL));
    hit.cmd   = (cpu_addr == IW'(IDX_CMD));
    hit.caddr = (cpu_addr == IW'(IDX_CADDR));
    hit.cdata = (cpu_addr == IW'(IDX_CDATA));
    wr_hit    = (acc && cpu_we) ? hit : '0;
  end

  cfgwin_regs #(.DW(DW), .MASK(CADDR_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr(wr_hit), .wdata(host_w),
    .ctrl_o(ctrl), .cmd_o(cmd), .caddr_o(caddr)
  );

  assign win_sw = !ctrl[ENDIAN_BIT];
  assign cfg_sw = !cmd[CMDSWAP_BIT] && (|caddr[DEV_HI:DEV_LO]);
  assign cfg_en = caddr[CEN_BIT];

  // write path: command swap composes with window swap
  cfgwin_bswap #(.DW(DW)) u_sw_win_in  (.en(win_sw), .din(cpu_wdata), .dout(host_w));
  cfgwin_bswap #(.DW(DW)) u_sw_cfg_out (.en(cfg_sw), .din(host_w),    .dout(cfg_w));
  // read path: command swap on the response, then window swap
  cfgwin_bswap #(.DW(DW)) u_sw_cfg_in  (.en(cfg_sw), .din(dn_rdata),  .dout(cfg_r));
  cfgwin_bswap #(.DW(DW)) u_sw_win_out (.en(win_sw), .din(sel_r),     .dout(rsp));

  always_comb begin
    local_r = '0;
    if (hit.ctrl)  local_r = ctrl;
    if (hit.cmd)   local_r = cmd;
    if (hit.caddr) local_r = caddr;
    if (hit.cdata) local_r = '1;
    sel_r = cpu_busy ? cfg_r : local_r;
  end

  cfgwin_cfgseq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .acc_i(acc), .we_i(cpu_we), .data_hit_i(hit.cdata), .cfg_en_i(cfg_en),
    .wdata_i(cfg_w), .rsp_i(rsp), .dn_rvalid_i(dn_rvalid),
    .busy_o(cpu_busy), .rvalid_o(cpu_rvalid), .rdata_o(cpu_rdata),
    .dn_req_o(dn_req), .dn_we_o(dn_we), .dn_wdata_o(dn_wdata)
  );

  assign dn_addr = caddr;

  // R8: bus 0 device 0 with window pass-through forwards data untouched
  a_r8_bus0_passthrough: assert property (@(posedge clk) disable iff (!rst_n_s)
    dn_req && dn_we && ctrl[ENDIAN_BIT] && (caddr[DEV_HI:DEV_LO] == '0)
      |-> dn_wdata == $past(cpu_wdata));

  // R2: with the endian bit set a command write is stored unchanged
  a_r2_straight_store: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc && cpu_we && hit.cmd && ctrl[ENDIAN_BIT] |=> cmd == $past(cpu_wdata));
endmodule

// File: tb/cfgwin_bridge_bench.sv
`timescale 1ns/1ps
module cfgwin_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [11:2] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_rvalid, cpu_busy;
  logic        dn_req, dn_we, dn_rvalid;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;

  int n_checks = 0;
  int n_err    = 0;
  bit cur_end  = 1'b0;

  localparam logic [11:0] A_CTRL = 12'h000, A_CMD = 12'h004,
                          A_CADDR = 12'h008, A_CDATA = 12'h00C;

  always #4 clk = ~clk;

  cfgwin_bridge u_cfgwin_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .cpu_busy(cpu_busy), .dn_req(dn_req),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] hostv(input logic [31:0] s);
    return cur_end ? s : bsw(s);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a[11:2]; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a[11:2];
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R11", "rvalid one cycle after read", 32'(cpu_rvalid), 32'd1);
    d = cpu_rdata;
  endtask

  task automatic set_ctrl(input bit e);
    wr(A_CTRL, hostv(e ? 32'h0000_1000 : 32'h0));
    cur_end = e;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "busy after reset", 32'(cpu_busy), 32'd0);
    chk("R1", "rvalid after reset", 32'(cpu_rvalid), 32'd0);
    chk("R1", "dn_req after reset", 32'(dn_req), 32'd0);
    rd(A_CTRL, v);  chk("R1", "ctrl reset", v, 32'h0);
    rd(A_CMD, v);   chk("R1", "cmd reset", v, 32'h0);
    rd(A_CADDR, v); chk("R1", "caddr reset", v, 32'h0);
  endtask

  task automatic t_window_swap;
    logic [31:0] v;
    cur_end = 1'b0;
    wr(A_CMD, 32'h1122_3344);
    rd(A_CMD, v);  chk("R1", "swap active after reset, round trip", v, 32'h1122_3344);
    wr(A_CTRL, 32'h0010_0000);
    cur_end = 1'b1;
    rd(A_CTRL, v); chk("R2", "endian bit set via swapped write", v, 32'h0000_1000);
    rd(A_CMD, v);  chk("R2", "word stored reversed", v, 32'h4433_2211);
    wr(A_CMD, 32'hA1B2_C3D4);
    rd(A_CMD, v);  chk("R2", "pass-through", v, 32'hA1B2_C3D4);
    wr(A_CTRL, 32'h0);
    cur_end = 1'b0;
    rd(A_CTRL, v); chk("R2", "endian cleared", v, 32'h0);
    rd(A_CMD, v);  chk("R2", "read reversed", v, 32'hD4C3_B2A1);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(A_CMD, hostv(32'h0000_005A));
    wr(12'h010, 32'hDEAD_BEEF);
    rd(12'h010, v); chk("R3", "unmapped 0x010 reads zero", v, 32'h0);
    wr(12'h804, 32'h0BAD_F00D);
    rd(12'h804, v); chk("R3", "unmapped 0x804 reads zero", v, 32'h0);
    rd(12'hFFC, v); chk("R3", "unmapped 0xFFC reads zero", v, 32'h0);
    rd(A_CMD, v);   chk("R3", "cmd untouched by unmapped writes", v, hostv(32'h0000_005A));
  endtask

  task automatic t_addr_mask;
    logic [31:0] v;
    wr(A_CADDR, hostv(32'hFFFF_FFFF));
    rd(A_CADDR, v); chk("R4", "mask on read", v, hostv(32'h80FF_FFFC));
    chk("R4", "dn_addr mask", dn_addr, 32'h80FF_FFFC);
    wr(A_CADDR, hostv(32'h7F00_0003));
    rd(A_CADDR, v); chk("R4", "masked-out bits zero", v, 32'h0);
  endtask

  task automatic t_disabled(input bit e);
    set_ctrl(e);
    wr(A_CADDR, hostv(32'h0000_1800));
    wr(A_CDATA, 32'h1357_9BDF);
    chk("R5", "no request on disabled write", 32'(dn_req), 32'd0);
    @(negedge clk);
    chk("R5", "still no request", 32'(dn_req), 32'd0);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A_CDATA[11:2];
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R6", "rvalid on disabled read", 32'(cpu_rvalid), 32'd1);
    chk("R6", "all ones", cpu_rdata, 32'hFFFF_FFFF);
    chk("R6", "no request", 32'(dn_req), 32'd0);
    chk("R6", "not busy", 32'(cpu_busy), 32'd0);
  endtask

  task automatic t_cfg(input bit e, input bit c, input logic [31:0] a);
    logic [31:0] v, h, d;
    bit sw, dev_nz;
    string rq;
    dev_nz = (a[23:11] != 13'h0);
    rq = dev_nz ? "R7" : "R8";
    sw = (!e) ^ (!c && dev_nz);
    h = 32'h1234_5678 ^ {a[15:0], 16'h0};
    d = 32'hCAFE_0123 ^ {16'h0, a[15:0]};
    set_ctrl(e);
    wr(A_CMD, hostv({31'b0, c}));
    wr(A_CADDR, hostv(a));
    wr(A_CDATA, h);
    chk("R9", "write req", 32'(dn_req), 32'd1);
    chk("R9", "write flag", 32'(dn_we), 32'd1);
    chk("R9", "address word", dn_addr, a & 32'h80FF_FFFC);
    chk(rq, "write data", dn_wdata, sw ? bsw(h) : h);
    @(negedge clk);
    chk("R9", "write req single pulse", 32'(dn_req), 32'd0);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A_CDATA[11:2];
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R9", "read req", 32'(dn_req), 32'd1);
    chk("R9", "read flag", 32'(dn_we), 32'd0);
    chk("R10", "busy after read req", 32'(cpu_busy), 32'd1);
    chk("R10", "no early rvalid", 32'(cpu_rvalid), 32'd0);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = A_CMD[11:2]; cpu_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    chk("R10", "still busy", 32'(cpu_busy), 32'd1);
    chk("R11", "no req while busy", 32'(dn_req), 32'd0);
    dn_rvalid = 1'b1; dn_rdata = d;
    @(negedge clk);
    dn_rvalid = 1'b0;
    chk("R10", "rvalid after response", 32'(cpu_rvalid), 32'd1);
    chk(rq, "read data", cpu_rdata, sw ? bsw(d) : d);
    chk("R10", "busy released", 32'(cpu_busy), 32'd0);
    rd(A_CMD, v);
    chk("R11", "write during busy ignored", v, hostv({31'b0, c}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
    cpu_wdata = '0; dn_rvalid = 1'b0; dn_rdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_window_swap();
    t_decode();
    t_addr_mask();
    t_disabled(1'b0);
    t_disabled(1'b1);
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 2; c++) begin
        t_cfg(e[0], c[0], 32'h8000_0040);
        t_cfg(e[0], c[0], 32'h8001_1A0C);
      end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule